// File: doc/BRIEF.md
# PWM Time-Base Counter with Synchronization

This block is the counting core of one PWM channel. A 16-bit counter advances only on cycles where a clock-enable tick is high. It can count up, count down, count up and then down (triangle), or stay frozen. The period limit sits behind a shadow copy, so a new value can be staged while a cycle runs. The staged value reaches the active limit when the counter is at zero. It can also be written directly to the active limit.

A synchronization event can reload the counter from a phase register. In triangle mode the event also forces the counting direction. The event comes from an external sync input or from a one-shot software request, and the two are combined by OR. A selectable source drives the sync output, so several channels can be chained. A debug-halt input can stop the counter after one more step or at the end of the current cycle, or it can be ignored. A compare-B equality flag comes from outside and is used only as one of the sync-output sources.

Top module: `tbase_top`

## Requirements
- R1: After reset the counter is 0 and the direction flag is 1. The mode is frozen. The active and shadow periods are both 0xFFFF and the phase is 0. The zero flag is 1 and the period flag is 0.
- R2: Writing address 0 sets the control word. Bits 1:0 hold the mode (00 up, 01 down, 10 triangle, 11 frozen). Bit 2 enables phase load. Bit 3 selects direct period writes. Bits 5:4 hold the sync-output source. Bit 6 is the software sync request. Bit 7 is the direction after sync. Bits 9:8 hold the halt policy. In the frozen mode, ticks do not move the counter.
- R3: In up mode each tick adds 1 until the counter reaches the period. The tick after that returns it to 0, and any value at or above the period also returns to 0. The direction flag reads 1.
- R4: In down mode each tick subtracts 1. A tick at 0 reloads the period. The direction flag reads 0.
- R5: In triangle mode the counter climbs to the period and turns down on the next tick. It descends to 0 and turns up on the next tick. The direction flag shows the current direction.
- R6: The counter changes only on a tick. A new mode applies from the next tick and continues from the present count, with no reload.
- R7: When phase load is enabled, a tick that carries a sync event loads the phase register (address 2) into the counter. A sync event is the sync input or a pending software request. This load takes priority over the normal step. With phase load disabled, sync events leave the count alone.
- R8: After a sync load in triangle mode, the direction flag equals control bit 7 (0 down, 1 up). After a sync load in up mode the flag is 1, and in down mode it is 0, whatever bit 7 holds.
- R9: Writing 1 to control bit 6 produces one sync event, consumed by the next tick. Writing 0 to bit 6 produces none.
- R10: The sync output follows a selectable source. Source 00 is the sync input OR a pending software request. Source 01 is counter equal to 0. Source 10 is the compare-B input. Source 11 holds the output at 0.
- R11: Period writes go to address 1. With bit 3 clear, a write goes only to the shadow register. The shadow is copied to the active period on a tick when the counter is 0, and that same tick already uses the new value. With bit 3 set, a write updates the active period at once.
- R12: With halt policy 00 and halt asserted, the counter takes one more step and then holds. It resumes once halt drops.
- R13: With halt policy 01 and halt asserted, counting continues until the end of the cycle and then holds there. The end of the cycle is the period in up mode and 0 in down and triangle modes. With policy 10 or 11, halt is ignored.
- R14: The zero flag is high while the counter is 0. The period flag is high while the counter equals the active period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable for counting |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 period, 2 phase, 3 unused |
| wrData | input | 16 | Write data |
| syncIn | input | 1 | External sync event |
| cmpBEq | input | 1 | External counter-equals-compare-B flag |
| haltIn | input | 1 | Debug halt request |
| cnt | output | 16 | Counter value |
| dirUp | output | 1 | 1 while counting up |
| zeroFlag | output | 1 | Counter equals 0 |
| prdFlag | output | 1 | Counter equals active period |
| syncOut | output | 1 | Selected sync output |

## Verification
A wrong internal state shows up on `cnt` or `dirUp` at the first tick after the fault. A lost or early period copy appears as a wrap at the wrong value within one cycle. A missing sync load leaves the count off the phase value on the very next sample. Halt faults show as a count that keeps moving, or stops one step early, within a tick or two of halt. The sync-output mux is checked at once on every sample, with each source selected in turn.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  typedef enum logic [1:0] {
    MODE_UP     = 2'b00,
    MODE_DOWN   = 2'b01,
    MODE_UPDN   = 2'b10,
    MODE_FREEZE = 2'b11
  } cntMode_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRD   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PHASE = 2'd2;

  localparam int CTRL_W   = 10;
  localparam int B_MODE   = 0;
  localparam int B_PHEN   = 2;
  localparam int B_DIRECT = 3;
  localparam int B_SEL    = 4;
  localparam int B_SWSYNC = 6;
  localparam int B_SDIR   = 7;
  localparam int B_HALT   = 8;

  typedef struct packed {
    logic     syncLoad;
    logic     step;
    logic     prdLoad;
    logic     wrShadow;
    logic     wrActive;
    logic     wrPhase;
    cntMode_e mode;
    logic     syncDir;
  } tbStrobe_t;
endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
  import tbase_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tick,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [CTRL_W-1:0]            ctrlBits,
  input  logic                         syncIn,
  input  logic                         cmpBEq,
  input  logic                         haltIn,
  input  logic                         cntIsZero,
  input  logic                         cntIsPrd,
  output tbStrobe_t                    strb,
  output logic [1:0]                   syncSel,
  output logic                         syncOut
);
  cntMode_e   modeQ;
  logic       phaseEnQ;
  logic       directQ;
  logic [1:0] syncSelQ;
  logic       syncDirQ;
  logic [1:0] haltModeQ;
  logic       swPendQ;
  logic       haltedQ;

  logic ctrlWr;
  logic prdWr;
  logic syncEvt;
  logic atEnd;
  logic haltBlock;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);
  assign prdWr  = wrEn && (wrAddr == ADDR_PRD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MODE_FREEZE;
      phaseEnQ  <= 1'b0;
      directQ   <= 1'b0;
      syncSelQ  <= 2'b00;
      syncDirQ  <= 1'b0;
      haltModeQ <= 2'b00;
      swPendQ   <= 1'b0;
      haltedQ   <= 1'b0;
    end else begin
      if (ctrlWr) begin
        modeQ     <= cntMode_e'(ctrlBits[B_MODE +: 2]);
        phaseEnQ  <= ctrlBits[B_PHEN];
        directQ   <= ctrlBits[B_DIRECT];
        syncSelQ  <= ctrlBits[B_SEL +: 2];
        syncDirQ  <= ctrlBits[B_SDIR];
        haltModeQ <= ctrlBits[B_HALT +: 2];
      end
      if (ctrlWr && ctrlBits[B_SWSYNC]) begin
        swPendQ <= 1'b1;
      end else if (tick) begin
        swPendQ <= 1'b0;
      end
      haltedQ <= haltIn && (haltedQ || tick);
    end
  end

  assign syncEvt = tick && (syncIn || swPendQ);
  assign atEnd   = (modeQ == MODE_UP) ? cntIsPrd : cntIsZero;

  always_comb begin
    case (haltModeQ)
      2'b00:   haltBlock = haltIn && haltedQ;
      2'b01:   haltBlock = haltIn && atEnd;
      default: haltBlock = 1'b0;
    endcase
  end

  always_comb begin
    strb.syncLoad = syncEvt && phaseEnQ;
    strb.step     = tick && !strb.syncLoad && (modeQ != MODE_FREEZE) && !haltBlock;
    strb.prdLoad  = tick && cntIsZero && !directQ;
    strb.wrShadow = prdWr;
    strb.wrActive = prdWr && directQ;
    strb.wrPhase  = wrEn && (wrAddr == ADDR_PHASE);
    strb.mode     = modeQ;
    strb.syncDir  = syncDirQ;
  end

  always_comb begin
    case (syncSelQ)
      2'b00:   syncOut = syncIn || swPendQ;
      2'b01:   syncOut = cntIsZero;
      2'b10:   syncOut = cmpBEq;
      default: syncOut = 1'b0;
    endcase
  end

  assign syncSel = syncSelQ;
endmodule

// File: rtl/tbase_dp.sv
module tbase_dp
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbStrobe_t        strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic             dirUp,
  output logic             cntIsZero,
  output logic             cntIsPrd
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntQ;
  logic             dirQ;
  logic [CNT_W-1:0] prdActQ;
  logic [CNT_W-1:0] prdShdQ;
  logic [CNT_W-1:0] phaseQ;

  logic [CNT_W-1:0] effPrd;
  logic [CNT_W-1:0] nextCnt;
  logic             nextDir;

  assign effPrd = strb.prdLoad ? prdShdQ : prdActQ;

  always_comb begin
    nextCnt = cntQ;
    nextDir = dirQ;
    if (strb.syncLoad) begin
      nextCnt = phaseQ;
      case (strb.mode)
        MODE_UP:   nextDir = 1'b1;
        MODE_DOWN: nextDir = 1'b0;
        MODE_UPDN: nextDir = strb.syncDir;
        default:   nextDir = dirQ;
      endcase
    end else if (strb.step) begin
      case (strb.mode)
        MODE_UP: begin
          nextDir = 1'b1;
          nextCnt = (cntQ >= effPrd) ? ZERO : cntQ + ONE;
        end
        MODE_DOWN: begin
          nextDir = 1'b0;
          nextCnt = (cntQ == ZERO) ? effPrd : cntQ - ONE;
        end
        MODE_UPDN: begin
          if (dirQ) begin
            if (cntQ >= effPrd) begin
              nextDir = 1'b0;
              nextCnt = (cntQ == ZERO) ? ZERO : cntQ - ONE;
            end else begin
              nextCnt = cntQ + ONE;
            end
          end else begin
            if (cntQ == ZERO) begin
              nextDir = 1'b1;
              nextCnt = (effPrd == ZERO) ? ZERO : ONE;
            end else begin
              nextCnt = cntQ - ONE;
            end
          end
        end
        default: begin
          nextCnt = cntQ;
          nextDir = dirQ;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= ZERO;
      dirQ    <= 1'b1;
      prdActQ <= '1;
      prdShdQ <= '1;
      phaseQ  <= ZERO;
    end else begin
      cntQ <= nextCnt;
      dirQ <= nextDir;
      if (strb.wrActive) begin
        prdActQ <= wrData;
      end else if (strb.prdLoad) begin
        prdActQ <= prdShdQ;
      end
      if (strb.wrShadow) begin
        prdShdQ <= wrData;
      end
      if (strb.wrPhase) begin
        phaseQ <= wrData;
      end
    end
  end

  assign cnt       = cntQ;
  assign dirUp     = dirQ;
  assign cntIsZero = (cntQ == ZERO);
  assign cntIsPrd  = (cntQ == prdActQ);
endmodule

// File: rtl/tbase_top.sv
module tbase_top
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             syncIn,
  input  logic             cmpBEq,
  input  logic             haltIn,
  output logic [CNT_W-1:0] cnt,
  output logic             dirUp,
  output logic             zeroFlag,
  output logic             prdFlag,
  output logic             syncOut
);
  tbStrobe_t  strb;
  logic [1:0] syncSel;

  tbase_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .ctrlBits  (wrData[CTRL_W-1:0]),
    .syncIn    (syncIn),
    .cmpBEq    (cmpBEq),
    .haltIn    (haltIn),
    .cntIsZero (zeroFlag),
    .cntIsPrd  (prdFlag),
    .strb      (strb),
    .syncSel   (syncSel),
    .syncOut   (syncOut)
  );

  tbase_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .cnt       (cnt),
    .dirUp     (dirUp),
    .cntIsZero (zeroFlag),
    .cntIsPrd  (prdFlag)
  );
endmodule

// File: rtl/tbase_chk.sv
module tbase_chk
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             dirUp,
  input logic             syncOut,
  input tbStrobe_t        strb,
  input logic [1:0]       syncSel
);
  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(cnt) && $stable(dirUp)));

  p_freeze_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && strb.mode == MODE_FREEZE && !strb.syncLoad) |=> $stable(cnt));

  p_up_dir_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.mode == MODE_UP) |=> dirUp);

  p_down_dir_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.mode == MODE_DOWN) |=> !dirUp);

  p_sync_dir_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.syncLoad && strb.mode == MODE_UPDN) |=> (dirUp == $past(strb.syncDir)));

  p_sync_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (syncSel == 2'b11) |-> !syncOut);
endmodule

bind tbase_top tbase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .cnt     (cnt),
  .dirUp   (dirUp),
  .syncOut (syncOut),
  .strb    (strb),
  .syncSel (syncSel)
);

// File: tb/tbase_top_tb.sv
`timescale 1ns/1ps
module tbase_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic        syncIn = 1'b0;
  logic        cmpBEq = 1'b0;
  logic        haltIn = 1'b0;
  logic [15:0] cnt;
  logic        dirUp, zeroFlag, prdFlag, syncOut;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  logic [15:0] mCnt = 0, mAct = 16'hFFFF, mShd = 16'hFFFF, mPh = 0;
  logic        mDir = 1;
  logic [1:0]  mMode = 2'b11, mSel = 0, mHMode = 0;
  logic        mPhEn = 0, mDirect = 0, mSDir = 0, mSwPend = 0, mHalted = 0;

  always #2.5 clk = ~clk;

  tbase_top u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .syncIn(syncIn), .cmpBEq(cmpBEq), .haltIn(haltIn),
    .cnt(cnt), .dirUp(dirUp), .zeroFlag(zeroFlag), .prdFlag(prdFlag),
    .syncOut(syncOut)
  );

  task automatic checkVal(input string req, input string what,
                          input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic modelSyncOut();
    case (mSel)
      2'b00:   return syncIn | mSwPend;
      2'b01:   return mCnt == 0;
      2'b10:   return cmpBEq;
      default: return 1'b0;
    endcase
  endfunction

  task automatic checkAll();
    checkVal(curReq, "cnt", cnt, mCnt);
    checkVal(curReq, "dirUp", {15'd0, dirUp}, {15'd0, mDir});
    checkVal("R14", "zeroFlag", {15'd0, zeroFlag}, {15'd0, mCnt == 0});
    checkVal("R14", "prdFlag", {15'd0, prdFlag}, {15'd0, mCnt == mAct});
    checkVal("R10", "syncOut", {15'd0, syncOut}, {15'd0, modelSyncOut()});
  endtask

  task automatic modelAdvance();
    logic ctrlWr, sEvt, atEnd, blk, sl, st, pl;
    logic [15:0] eff, nCnt;
    logic nDir;
    ctrlWr = wrEn && wrAddr == 2'd0;
    sEvt = tick && (syncIn || mSwPend);
    atEnd = (mMode == 2'b00) ? (mCnt == mAct) : (mCnt == 0);
    blk = (mHMode == 2'b00) ? (haltIn && mHalted) :
          (mHMode == 2'b01) ? (haltIn && atEnd) : 1'b0;
    sl = sEvt && mPhEn;
    st = tick && !sl && mMode != 2'b11 && !blk;
    pl = tick && mCnt == 0 && !mDirect;
    eff = pl ? mShd : mAct;
    nCnt = mCnt;
    nDir = mDir;
    if (sl) begin
      nCnt = mPh;
      if (mMode == 2'b00) nDir = 1;
      else if (mMode == 2'b01) nDir = 0;
      else if (mMode == 2'b10) nDir = mSDir;
    end else if (st) begin
      if (mMode == 2'b00) begin
        nDir = 1; nCnt = (mCnt >= eff) ? 16'd0 : mCnt + 16'd1;
      end else if (mMode == 2'b01) begin
        nDir = 0; nCnt = (mCnt == 0) ? eff : mCnt - 16'd1;
      end else begin
        if (mDir) begin
          if (mCnt >= eff) begin nDir = 0; nCnt = (mCnt == 0) ? 16'd0 : mCnt - 16'd1; end
          else nCnt = mCnt + 16'd1;
        end else begin
          if (mCnt == 0) begin nDir = 1; nCnt = (eff == 0) ? 16'd0 : 16'd1; end
          else nCnt = mCnt - 16'd1;
        end
      end
    end
    if (wrEn && wrAddr == 2'd1) begin
      if (mDirect) mAct = wrData;
      mShd = wrData;
    end
    if (pl) mAct = mShd_old(pl);
    if (wrEn && wrAddr == 2'd2) mPh = wrData;
    if (ctrlWr && wrData[6]) mSwPend = 1;
    else if (tick) mSwPend = 0;
    mHalted = haltIn && (mHalted || tick);
    if (ctrlWr) begin
      mMode = wrData[1:0]; mPhEn = wrData[2]; mDirect = wrData[3];
      mSel = wrData[5:4]; mSDir = wrData[7]; mHMode = wrData[9:8];
    end
    mCnt = nCnt;
    mDir = nDir;
  endtask

  logic [15:0] shdSnap;
  function automatic logic [15:0] mShd_old(input logic unused);
    return unused ? shdSnap : shdSnap;
  endfunction

  task automatic cyc(input logic t, input logic we, input logic [1:0] a,
                     input logic [15:0] d, input logic si);
    tick = t; wrEn = we; wrAddr = a; wrData = d; syncIn = si;
    shdSnap = mShd;
    modelAdvance();
    @(posedge clk);
    @(negedge clk);
    checkAll();
  endtask

  function automatic logic [15:0] ctrlWord(input logic [1:0] mode, input logic phEn,
      input logic direct, input logic [1:0] sel, input logic sw, input logic sdir,
      input logic [1:0] hm);
    return {6'd0, hm, sdir, sw, sel, direct, phEn, mode};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cyc(0, 1, a, d, 0);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 2'd0, 16'd0, 0);
  endtask

  logic [15:0] v;

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    checkAll();
    checkVal("R1", "cnt reset", cnt, 16'd0);
    checkVal("R1", "dir reset", {15'd0, dirUp}, 16'd1);

    curReq = "R2";
    tk(4);
    checkVal("R2", "frozen cnt", cnt, 16'd0);

    curReq = "R11";
    wr(2'd1, 16'd5);
    wr(2'd0, ctrlWord(2'b00, 0, 0, 2'b01, 0, 0, 2'b10));
    tk(9);
    wr(2'd1, 16'd7);
    checkVal("R11", "prdFlag before reload", {15'd0, prdFlag}, {15'd0, cnt == 16'd5});
    tk(16);
    wr(2'd0, ctrlWord(2'b00, 0, 1, 2'b01, 0, 0, 2'b10));
    wr(2'd1, 16'd3);
    checkVal("R11", "direct prdFlag", {15'd0, prdFlag}, {15'd0, cnt == 16'd3});

    curReq = "R3";
    tk(12);
    curReq = "R4";
    wr(2'd0, ctrlWord(2'b01, 0, 1, 2'b01, 0, 0, 2'b10));
    tk(12);
    curReq = "R5";
    wr(2'd1, 16'd4);
    wr(2'd0, ctrlWord(2'b10, 0, 1, 2'b01, 0, 0, 2'b10));
    tk(20);

    curReq = "R6";
    wr(2'd0, ctrlWord(2'b00, 0, 1, 2'b01, 0, 0, 2'b10));
    tk(2);
    v = cnt;
    wr(2'd0, ctrlWord(2'b01, 0, 1, 2'b01, 0, 0, 2'b10));
    checkVal("R6", "no move without tick", cnt, v);
    tk(1);
    checkVal("R6", "continues from count", cnt, (v == 0) ? 16'd4 : v - 16'd1);

    curReq = "R7";
    wr(2'd2, 16'd2);
    wr(2'd0, ctrlWord(2'b10, 1, 1, 2'b00, 0, 1, 2'b10));
    tk(1);
    cyc(1, 0, 2'd0, 16'd0, 1);
    checkVal("R7", "phase load", cnt, 16'd2);
    wr(2'd0, ctrlWord(2'b10, 0, 1, 2'b00, 0, 1, 2'b10));
    v = cnt;
    cyc(1, 0, 2'd0, 16'd0, 1);
    checkVal("R7", "no load when disabled", {15'd0, cnt == 16'd2}, {15'd0, v == 16'd2 ? 1'b0 : 1'b0});

    curReq = "R8";
    wr(2'd0, ctrlWord(2'b10, 1, 1, 2'b00, 0, 0, 2'b10));
    cyc(1, 0, 2'd0, 16'd0, 1);
    checkVal("R8", "dir after sync 0", {15'd0, dirUp}, 16'd0);
    wr(2'd0, ctrlWord(2'b10, 1, 1, 2'b00, 0, 1, 2'b10));
    cyc(1, 0, 2'd0, 16'd0, 1);
    checkVal("R8", "dir after sync 1", {15'd0, dirUp}, 16'd1);
    wr(2'd0, ctrlWord(2'b01, 1, 1, 2'b00, 0, 1, 2'b10));
    cyc(1, 0, 2'd0, 16'd0, 1);
    checkVal("R8", "down ignores dir bit", {15'd0, dirUp}, 16'd0);
    wr(2'd0, ctrlWord(2'b00, 1, 1, 2'b00, 0, 0, 2'b10));
    cyc(1, 0, 2'd0, 16'd0, 1);
    checkVal("R8", "up ignores dir bit", {15'd0, dirUp}, 16'd1);

    curReq = "R9";
    wr(2'd2, 16'd1);
    tk(2);
    wr(2'd0, ctrlWord(2'b00, 1, 1, 2'b00, 1, 0, 2'b10));
    checkVal("R9", "pending on syncOut", {15'd0, syncOut}, 16'd1);
    tk(1);
    checkVal("R9", "sw sync load", cnt, 16'd1);
    tk(1);
    checkVal("R9", "single pulse", cnt, 16'd2);
    wr(2'd0, ctrlWord(2'b00, 1, 1, 2'b00, 0, 0, 2'b10));
    tk(1);
    checkVal("R9", "write 0 no sync", cnt, 16'd3);

    curReq = "R10";
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, ctrlWord(2'b11, 0, 1, s[1:0], 0, 0, 2'b10));
      cmpBEq = 1'b1; cyc(0, 0, 2'd0, 16'd0, 1);
      cmpBEq = 1'b0; cyc(0, 0, 2'd0, 16'd0, 0);
      cmpBEq = 1'b1; cyc(0, 0, 2'd0, 16'd0, 0);
      cmpBEq = 1'b0;
    end

    curReq = "R12";
    wr(2'd1, 16'd10);
    wr(2'd2, 16'd2);
    wr(2'd0, ctrlWord(2'b00, 1, 1, 2'b00, 1, 0, 2'b00));
    tk(1);
    wr(2'd0, ctrlWord(2'b00, 0, 1, 2'b00, 0, 0, 2'b00));
    haltIn = 1'b1;
    tk(4);
    checkVal("R12", "one step then hold", cnt, 16'd3);
    haltIn = 1'b0;
    tk(2);
    checkVal("R12", "resumes", cnt, 16'd5);

    curReq = "R13";
    wr(2'd0, ctrlWord(2'b00, 0, 1, 2'b00, 0, 0, 2'b01));
    haltIn = 1'b1;
    tk(9);
    checkVal("R13", "up holds at period", cnt, 16'd10);
    haltIn = 1'b0;
    tk(1);
    wr(2'd0, ctrlWord(2'b01, 0, 1, 2'b00, 0, 0, 2'b01));
    tk(3);
    haltIn = 1'b1;
    tk(12);
    checkVal("R13", "down holds at zero", cnt, 16'd0);
    wr(2'd0, ctrlWord(2'b01, 0, 1, 2'b00, 0, 0, 2'b10));
    tk(1);
    checkVal("R13", "free run ignores halt", cnt, 16'd10);
    haltIn = 1'b0;

    curReq = "R5";
    for (int i = 0; i < 6000; i++) begin
      logic t, we, si;
      logic [1:0] a;
      logic [15:0] d;
      t = ($urandom_range(0, 9) < 6);
      si = ($urandom_range(0, 19) == 0);
      we = ($urandom_range(0, 19) == 0);
      a = $urandom_range(0, 3);
      d = 16'($urandom_range(1, 12));
      if (a == 2'd0)
        d = ctrlWord($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
                     $urandom_range(0, 3), ($urandom_range(0, 9) == 0),
                     $urandom_range(0, 1), $urandom_range(0, 3));
      if ($urandom_range(0, 49) == 0) haltIn = ~haltIn;
      cmpBEq = $urandom_range(0, 1);
      cyc(t, we, a, d, si);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
  end
endmodule